// File: doc/BRIEF.md
# Directory Home Node for Invalidation Coherence

This block is the home node of a small shared-memory multiprocessor. For every memory block it holds the data word and a set of processors that hold a shared copy. Requesters present read misses and write misses on one request port. A read returns the committed value of the block and enrolls the reader as a sharer. A write sends one invalidation message, addressed to every other sharer of that block. It then waits for an acknowledgement from each of those processors. Only then does it commit the data and report completion to the writer.

Completion is tied to the acknowledgements and never to the moment the invalidation leaves. This is why the block keeps the processors' views consistent. Invalidations may take different and unbounded times to arrive, and acknowledgements may come back in any order and in any cycle. The writer may not start its next memory operation before the done response, so no processor can observe a newer write while still holding a stale copy of an older one. While a write is outstanding, the home node accepts no further writes and no reads of that block. Reads of other blocks continue.

Top module: `coh_home`

## Requirements
- R1: After reset no response and no invalidation is driven, the request port is ready, every block reads as zero, and no block has any sharer.
- R2: An accepted read returns a response in the next cycle with rsp_write low, rsp_dst equal to the requester, rsp_blk equal to the block, and rsp_data equal to the block's committed value.
- R3: An accepted read adds the requester to the block's sharer set.
- R4: An accepted write to a block that has sharers other than the writer raises inv_valid for exactly one cycle, in the next cycle. inv_blk names the block. inv_mask holds one bit per processor (bit i for processor i), set for every sharer except the writer.
- R5: A write with outstanding invalidations produces its done response (rsp_write high, rsp_dst the writer, rsp_data the written value) exactly one cycle after the cycle in which the last missing acknowledgement is presented on ack_in. Acknowledgements may arrive in any order and spread over any number of cycles, and no done response appears before the last one.
- R6: An acknowledgement bit from a processor that is not awaited for the current write has no effect on completion.
- R7: A write to a block with no sharer other than the writer sends no invalidation and gives its done response in the next cycle.
- R8: When a write completes, the block's value becomes the written data and its sharer set holds only the writer.
- R9: While a write is outstanding, req_ready is low for any write and for reads of the same block, and high for reads of other blocks.
- R10: In the cycle in which an outstanding write completes, req_ready is low, so at most one response is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block index |
| req_wdata | input | DW | Write data |
| inv_valid | output | 1 | Invalidation message valid (one cycle) |
| inv_mask | output | NPROC | Processors to invalidate, bit i for processor i |
| inv_blk | output | $clog2(NBLK) | Block being invalidated |
| ack_in | input | NPROC | Invalidation acknowledgements, bit i from processor i |
| rsp_valid | output | 1 | Response valid (one cycle) |
| rsp_write | output | 1 | 1 = write done, 0 = read data |
| rsp_dst | output | $clog2(NPROC) | Processor the response is for |
| rsp_blk | output | $clog2(NBLK) | Block index of the response |
| rsp_data | output | DW | Read value, or the value just committed |

## Verification
A read's data and a write's invalidation appear one cycle after the edge that accepts the request. A write without other sharers is done in that same next cycle. A write with sharers is done one cycle after the edge that samples its last acknowledgement. The driver puts each expected response into the queue before the accepting or completing edge. A monitor pops the queue at every falling edge that shows rsp_valid, and one tenth of a period after that falling edge the driver requires the queue to be empty. A response that is early or unexpected therefore meets an empty queue, and one that is late or missing leaves the queue non-empty. Invalidations and ready levels are checked directly at the falling edge where they are due.

// File: rtl/coh_home.sv
module coh_home #(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 16,
  localparam int SW = $clog2(NPROC),
  localparam int BW = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [SW-1:0]    req_src,
  input  logic [BW-1:0]    req_blk,
  input  logic [DW-1:0]    req_wdata,
  output logic             inv_valid,
  output logic [NPROC-1:0] inv_mask,
  output logic [BW-1:0]    inv_blk,
  input  logic [NPROC-1:0] ack_in,
  output logic             rsp_valid,
  output logic             rsp_write,
  output logic [SW-1:0]    rsp_dst,
  output logic [BW-1:0]    rsp_blk,
  output logic [DW-1:0]    rsp_data
);

  logic [NPROC-1:0] sharers [NBLK];
  logic [DW-1:0]    mem     [NBLK];

  logic             pend;
  logic [NPROC-1:0] wait_set;
  logic [SW-1:0]    psrc;
  logic [BW-1:0]    pblk;
  logic [DW-1:0]    pdata;

  wire [NPROC-1:0] left   = wait_set & ~ack_in;
  wire             fin    = pend && (left == '0);
  wire [NPROC-1:0] self   = NPROC'(1) << req_src;
  wire [NPROC-1:0] others = sharers[req_blk] & ~self;
  wire             take   = req_valid && req_ready;

  assign req_ready = !pend || (!req_write && req_blk != pblk && !fin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        sharers[b] <= '0;
        mem[b]     <= '0;
      end
      pend      <= 1'b0;
      wait_set  <= '0;
      psrc      <= '0;
      pblk      <= '0;
      pdata     <= '0;
      inv_valid <= 1'b0;
      inv_mask  <= '0;
      inv_blk   <= '0;
      rsp_valid <= 1'b0;
      rsp_write <= 1'b0;
      rsp_dst   <= '0;
      rsp_blk   <= '0;
      rsp_data  <= '0;
    end else begin
      inv_valid <= 1'b0;
      rsp_valid <= 1'b0;
      if (fin) begin
        pend          <= 1'b0;
        wait_set      <= '0;
        mem[pblk]     <= pdata;
        sharers[pblk] <= NPROC'(1) << psrc;
        rsp_valid     <= 1'b1;
        rsp_write     <= 1'b1;
        rsp_dst       <= psrc;
        rsp_blk       <= pblk;
        rsp_data      <= pdata;
      end else if (pend) begin
        wait_set <= left;
      end
      if (take) begin
        if (req_write) begin
          if (others == '0) begin
            mem[req_blk]     <= req_wdata;
            sharers[req_blk] <= self;
            rsp_valid        <= 1'b1;
            rsp_write        <= 1'b1;
            rsp_dst          <= req_src;
            rsp_blk          <= req_blk;
            rsp_data         <= req_wdata;
          end else begin
            pend      <= 1'b1;
            wait_set  <= others;
            psrc      <= req_src;
            pblk      <= req_blk;
            pdata     <= req_wdata;
            inv_valid <= 1'b1;
            inv_mask  <= others;
            inv_blk   <= req_blk;
          end
        end else begin
          sharers[req_blk] <= sharers[req_blk] | self;
          rsp_valid        <= 1'b1;
          rsp_write        <= 1'b0;
          rsp_dst          <= req_src;
          rsp_blk          <= req_blk;
          rsp_data         <= mem[req_blk];
        end
      end
    end
  end

  p_read_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (rsp_valid && !rsp_write));

  p_inv_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !inv_valid);

  p_inv_not_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (!inv_mask[psrc] && inv_mask != '0));

  p_no_early_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && left != '0) |=> !(rsp_valid && rsp_write));

  p_no_write_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !(req_valid && req_ready && req_write));

  p_one_rsp_at_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !req_ready);

endmodule

// File: tb/coh_home_test.sv
module coh_home_test;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_src = 0;
  logic [2:0]  req_blk = 0;
  logic [15:0] req_wdata = 0;
  logic [3:0]  ack_in = 0;
  logic        req_ready, inv_valid, rsp_valid, rsp_write;
  logic [3:0]  inv_mask;
  logic [2:0]  inv_blk, rsp_blk;
  logic [1:0]  rsp_dst;
  logic [15:0] rsp_data;

  coh_home uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_src(req_src), .req_blk(req_blk), .req_wdata(req_wdata),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_blk(inv_blk), .ack_in(ack_in),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_dst(rsp_dst), .rsp_blk(rsp_blk),
    .rsp_data(rsp_data));

  always #(PERIOD/2) clk = ~clk;

  typedef struct packed {logic w; logic [1:0] dst; logic [2:0] blk; logic [15:0] data;} exp_t;
  exp_t q[$];
  int vectors = 0, errs = 0;
  logic [3:0]  sh [8];
  logic [15:0] mv [8];
  int pw_src, pw_blk, pw_data;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    exp_t got;
    got = {rsp_write, rsp_dst, rsp_blk, rsp_data};
    if (q.size() == 0) chk(0, "R5", "unexpected response", int'(got), 0);
    else begin
      exp_t e;
      e = q.pop_front();
      chk(got == e, e.w ? "R5" : "R2", "response", int'(got), int'(e));
    end
  end

  // caller stands just after a falling edge
  task automatic issue(bit w, int src, int blk, int data, bit exp_rdy, bit track_done);
    logic [3:0] others;
    bit due = 0;
    req_valid = 1; req_write = w; req_src = 2'(src); req_blk = 3'(blk); req_wdata = 16'(data);
    #1 chk(req_ready == exp_rdy, "R9", "req_ready", req_ready, exp_rdy);
    others = sh[blk] & ~(4'b1 << src);
    if (exp_rdy) begin
      if (!w) begin
        q.push_back({1'b0, 2'(src), 3'(blk), mv[blk]});
        sh[blk] = sh[blk] | (4'b1 << src);
        due = 1;
      end else if (others == 0) begin
        q.push_back({1'b1, 2'(src), 3'(blk), 16'(data)});
        mv[blk] = 16'(data); sh[blk] = 4'b1 << src;
        due = track_done;
      end else begin
        pw_src = src; pw_blk = blk; pw_data = data;
      end
    end
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk); #1;
    if (due) chk(q.size() == 0, w ? "R7" : "R2", "response due", q.size(), 0);
    if (exp_rdy && w) begin
      chk(inv_valid == (others != 0), others != 0 ? "R4" : "R7", "inv_valid", inv_valid, others != 0);
      if (others != 0) begin
        chk(inv_mask == others, "R4", "inv_mask", inv_mask, others);
        chk(inv_blk == 3'(blk), "R4", "inv_blk", inv_blk, blk);
      end
    end
  endtask

  task automatic ack(logic [3:0] m, bit done, string req);
    ack_in = m;
    if (done) begin
      q.push_back({1'b1, 2'(pw_src), 3'(pw_blk), 16'(pw_data)});
      mv[pw_blk] = 16'(pw_data); sh[pw_blk] = 4'b1 << pw_src;
    end
    @(posedge clk); #1 ack_in = 0;
    @(negedge clk); #1;
    chk(q.size() == 0, req, "done timing", q.size(), 0);
    chk(inv_valid == 0, "R4", "inv single cycle", inv_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R5", "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) begin sh[b] = 0; mv[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    chk(inv_valid == 0, "R1", "inv_valid", inv_valid, 0);
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);

    issue(0, 1, 2, 0, 1, 1);            // R2 zero after reset, R3
    issue(0, 3, 2, 0, 1, 1);
    issue(0, 0, 5, 0, 1, 1);
    issue(1, 2, 2, 16'hA5A5, 1, 1);     // R4 mask 1010
    ack(4'b0001, 0, "R6");              // not awaited
    ack(4'b1000, 0, "R5");              // partial
    issue(1, 0, 5, 16'h1111, 0, 1);     // R9 write blocked
    issue(0, 0, 2, 0, 0, 1);            // R9 same-block read blocked
    issue(0, 1, 5, 0, 1, 1);            // R9 other-block read allowed
    // R10: final ack together with a read of another block
    req_valid = 1; req_write = 0; req_src = 3; req_blk = 6;
    ack_in = 4'b0010;
    q.push_back({1'b1, 2'(pw_src), 3'(pw_blk), 16'(pw_data)});
    mv[pw_blk] = 16'(pw_data); sh[pw_blk] = 4'b1 << pw_src;
    #1 chk(req_ready == 0, "R10", "ready at completion", req_ready, 0);
    @(posedge clk); #1 begin ack_in = 0; req_valid = 0; end
    @(negedge clk); #1 chk(q.size() == 0, "R5", "done after last ack", q.size(), 0);

    issue(0, 0, 2, 0, 1, 1);            // R8 reads A5A5
    issue(1, 0, 2, 16'h1234, 1, 1);     // R8 mask 0100 only
    ack(4'b0100, 1, "R5");
    issue(0, 3, 2, 0, 1, 1);            // R8 reads 1234
    issue(1, 3, 7, 16'h7777, 1, 1);     // R7 no sharers
    issue(1, 1, 5, 16'h5555, 1, 1);     // R4 mask 0001
    ack(4'b0001, 1, "R5");
    issue(1, 2, 5, 16'h6666, 1, 1);     // R8 mask 0010 (writer only left)
    ack(4'b0010, 1, "R8");
    issue(0, 2, 5, 0, 1, 1);
    issue(0, 1, 7, 0, 1, 1);

    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R5", "outstanding responses", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule